// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block derives a serial bit-rate tick from the system clock. The rate is set by two fields written together as one 32-bit configuration word: an 8-bit integer prescale and a 16-bit fractional step. The prescaler divides the clock by (scale + 1). Each prescaled enable adds the step into a 17-bit phase accumulator, and every carry out of that accumulator produces a single-cycle tick. The resulting rate is clk / (scale + 1) × step / 2^17. With a 16-bit step, the generator can reach many rates that a plain integer divider cannot.

A two-state machine gates the datapath. In ST_HOLD the prescaler and accumulator are held at zero and no tick is produced. In ST_RUN they advance.
- The GO transition (ST_HOLD to ST_RUN) is taken when the enable input is high and the step that will be in force after the current clock edge is non-zero.
- The STOP transition (ST_RUN to ST_HOLD) is taken when either condition fails.

Every configuration write clears the prescaler and the accumulator, so a new rate always starts from phase zero. Dropping the enable also restarts the phase.

Top module: `frac_baud_gen`

## Requirements
- R1: After reset, scale and step are both 0, the machine is in ST_HOLD, and `tick` stays low until a configuration word with a non-zero step is written while `en` is high.
- R2: A configuration write takes scale from `cfg_wdata[23:16]` and step from `cfg_wdata[15:0]` in the same cycle. Bits [31:24] have no effect on the tick rate.
- R3: Let a write with `en` high occur on edge E0. Over the next W edges, the number of ticks is floor(floor(W / (scale + 1)) × step / 2^17), which equals the rate formula within one tick.
- R4: Let the write occur on edge E0. The k-th prescaled enable happens on edge E(k·(scale+1)). The first tick is high for exactly the cycle after edge E(m·(scale+1)), where m = ceil(2^17 / step).
- R5: `tick` is never high in two consecutive cycles.
- R6: While `en` is low, no tick is produced. Raising `en` restarts the phase from zero, with the same timing as a fresh write.
- R7: While step is 0, the machine stays in ST_HOLD and no tick is produced.
- R8: A configuration write clears the prescaler and the accumulator. `tick` is low in the cycle after the write, even when the write lands mid-phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Generator enable; low holds and clears the phase |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 32 | Configuration word: scale at [23:16], step at [15:0] |
| tick | output | 1 | Single-cycle bit-rate tick |

## Verification
A wrong prescaler count or a wrong accumulator value changes the tick count within one window, and it moves the first tick after a write away from edge m·(scale+1). The bench therefore checks both the exact count and the exact first-tick position for every scale/step pair in its sweep. A fault in the clear or hold logic shows within a few cycles, as a tick in the cycle after a write or while `en` is low. A fault in the carry logic shows as back-to-back ticks.

// File: rtl/frac_baud_pkg.sv
`timescale 1ns/1ps
package frac_baud_pkg;
    localparam int CFG_W     = 32;
    localparam int SCALE_W   = 8;
    localparam int STEP_W    = 16;
    localparam int SCALE_LSB = 16;
    localparam int ACC_W     = STEP_W + 1;

    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } fbg_state_e;
endpackage

// File: rtl/fbg_cfg_reg.sv
`timescale 1ns/1ps
module fbg_cfg_reg #(
    parameter int CFG_W     = frac_baud_pkg::CFG_W,
    parameter int SCALE_W   = frac_baud_pkg::SCALE_W,
    parameter int STEP_W    = frac_baud_pkg::STEP_W,
    parameter int SCALE_LSB = frac_baud_pkg::SCALE_LSB
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr,
    input  logic [CFG_W-1:0]   wdata,
    output logic [SCALE_W-1:0] scale_q,
    output logic [STEP_W-1:0]  step_q,
    output logic [STEP_W-1:0]  step_nx
);
    // Step value in force after the coming edge
    always_comb begin
        step_nx = wr ? wdata[STEP_W-1:0] : step_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scale_q <= '0;
            step_q  <= '0;
        end else if (wr) begin
            scale_q <= wdata[SCALE_LSB +: SCALE_W];
            step_q  <= wdata[STEP_W-1:0];
        end
    end

    AST_CFG_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (scale_q == $past(wdata[SCALE_LSB +: SCALE_W])) && (step_q == $past(wdata[STEP_W-1:0]))); // R2
endmodule

// File: rtl/fbg_prescaler.sv
`timescale 1ns/1ps
module fbg_prescaler #(
    parameter int SCALE_W = frac_baud_pkg::SCALE_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               run,
    input  logic [SCALE_W-1:0] scale,
    output logic               pulse
);
    logic [SCALE_W-1:0] cnt_q;

    always_comb begin
        pulse = run && !clr && (cnt_q == scale);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == scale) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= scale); // R3
    AST_IDLE_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> !pulse); // R6
endmodule

// File: rtl/fbg_phase_acc.sv
`timescale 1ns/1ps
module fbg_phase_acc #(
    parameter int STEP_W = frac_baud_pkg::STEP_W,
    parameter int ACC_W  = frac_baud_pkg::ACC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    input  logic [STEP_W-1:0] step,
    output logic              tick
);
    localparam int SUM_W = ACC_W + 1;

    logic [ACC_W-1:0] acc_q;
    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {1'b0, acc_q} + SUM_W'(step);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (clr) begin
            acc_q <= '0;
            tick  <= 1'b0;
        end else if (adv) begin
            acc_q <= sum[ACC_W-1:0];
            tick  <= sum[ACC_W];
        end else begin
            tick  <= 1'b0;
        end
    end

    AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R5
    AST_CLR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick); // R8
endmodule

// File: rtl/frac_baud_gen.sv
`timescale 1ns/1ps
module frac_baud_gen #(
    parameter int CFG_W     = frac_baud_pkg::CFG_W,
    parameter int SCALE_W   = frac_baud_pkg::SCALE_W,
    parameter int STEP_W    = frac_baud_pkg::STEP_W,
    parameter int SCALE_LSB = frac_baud_pkg::SCALE_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tick
);
    import frac_baud_pkg::*;

    localparam int ACC_LEN = STEP_W + 1;

    logic [SCALE_W-1:0] scale_q;
    logic [STEP_W-1:0]  step_q;
    logic [STEP_W-1:0]  step_nx;
    fbg_state_e         state_q, state_d;
    logic               pre_run, acc_clr, pre_pulse;

    fbg_cfg_reg #(
        .CFG_W(CFG_W), .SCALE_W(SCALE_W), .STEP_W(STEP_W), .SCALE_LSB(SCALE_LSB)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(cfg_wdata),
        .scale_q(scale_q), .step_q(step_q), .step_nx(step_nx)
    );

    // Next-state: GO when enabled with a non-zero step, STOP otherwise
    always_comb begin
        unique case (state_q)
            ST_HOLD: state_d = (en && (step_nx != '0)) ? ST_RUN : ST_HOLD;
            ST_RUN:  state_d = (en && (step_nx != '0)) ? ST_RUN : ST_HOLD;
            default: state_d = ST_HOLD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
        end else begin
            state_q <= state_d;
        end
    end

    // State outputs
    always_comb begin
        unique case (state_q)
            ST_HOLD: begin
                pre_run = 1'b0;
                acc_clr = 1'b1;
            end
            ST_RUN: begin
                pre_run = 1'b1;
                acc_clr = cfg_wr;
            end
            default: begin
                pre_run = 1'b0;
                acc_clr = 1'b1;
            end
        endcase
    end

    fbg_prescaler #(.SCALE_W(SCALE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(cfg_wr), .run(pre_run),
        .scale(scale_q), .pulse(pre_pulse)
    );

    fbg_phase_acc #(.STEP_W(STEP_W), .ACC_W(ACC_LEN)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .adv(pre_pulse),
        .step(step_q), .tick(tick)
    );

    AST_HOLD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |=> !tick); // R6
    AST_RUN_NEEDS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |-> (step_q != '0)); // R7
    AST_WRITE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !tick); // R8
    AST_STOP_ON_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (state_q == ST_HOLD)); // R6
endmodule

// File: tb/frac_baud_gen_bench.sv
`timescale 1ns/1ps
module frac_baud_gen_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        tick;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    frac_baud_gen u_frac_baud_gen (
        .clk(clk), .rst_n(rst_n), .en(en), .cfg_wr(cfg_wr),
        .cfg_wdata(cfg_wdata), .tick(tick)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_wr    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_wr    = 1'b0;
    endtask

    // Samples after edges E1..Ew, counting ticks, first position and doubles
    task automatic run_window(input int w, output int cnt, output int first, output int dbl);
        logic prev;
        prev  = 1'b0;
        cnt   = 0;
        first = 0;
        dbl   = 0;
        for (int n = 1; n <= w; n++) begin
            @(posedge clk);
            #1;
            if (tick) begin
                cnt++;
                if (first == 0) first = n;
                if (prev) dbl++;
            end
            prev = tick;
        end
    endtask

    function automatic longint exp_count(input int w, input int s, input int st);
        longint ens;
        ens = longint'(w / (s + 1));
        return (ens * longint'(st)) >> 17;
    endfunction

    function automatic longint exp_first(input int s, input int st);
        longint m;
        m = (longint'(131072) + longint'(st) - 1) / longint'(st);
        return m * longint'(s + 1);
    endfunction

    task automatic sweep_one(input int s, input int st, input logic [7:0] junk, input int w);
        int cnt, first, dbl;
        longint ec, ef;
        write_cfg({junk, s[7:0], st[15:0]});
        run_window(w, cnt, first, dbl);
        ec = exp_count(w, s, st);
        check(cnt == ec, $sformatf("R3 count s=%0d step=%0d", s, st), cnt, ec);
        if (ec > 0) begin
            ef = exp_first(s, st);
            check(first == ef, $sformatf("R4 first tick s=%0d step=%0d", s, st), first, ef);
        end
        check(dbl == 0, $sformatf("R5 back-to-back s=%0d step=%0d", s, st), dbl, 0);
    endtask

    initial begin
        #(64'd200000 * 64'd20);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int cnt, first, dbl;
        int scales [6] = '{0, 1, 2, 3, 7, 255};
        int steps  [6] = '{1, 3, 4096, 12345, 32768, 65535};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        en    = 1'b1;
        #1;
        check(tick == 1'b0, "R1 tick low after reset", tick, 0);
        run_window(300, cnt, first, dbl);
        check(cnt == 0, "R1 no ticks before first write", cnt, 0);

        // R3 / R4 / R5 sweep, upper junk bits varied for R2
        foreach (scales[i]) begin
            foreach (steps[j]) begin
                sweep_one(scales[i], steps[j], 8'((i * 37 + j * 91) & 8'hFF), 1500);
            end
        end

        // R2: junk in [31:24] has no effect, fields land at [23:16] and [15:0]
        write_cfg(32'hA5_03_8000);
        run_window(800, cnt, first, dbl);
        check(cnt == exp_count(800, 3, 32768), "R2 field placement count", cnt, exp_count(800, 3, 32768));
        check(first == exp_first(3, 32768), "R2 field placement first", first, exp_first(3, 32768));

        // R8: rewrite mid-phase restarts phase from zero
        write_cfg(32'h0000_FFFF);
        run_window(4, cnt, first, dbl);
        write_cfg(32'h0000_FFFF);
        #1;
        check(tick == 1'b0, "R8 tick low after write", tick, 0);
        run_window(50, cnt, first, dbl);
        check(first == 3, "R8 first tick after mid-phase rewrite", first, 3);
        check(cnt == exp_count(50, 0, 65535), "R8 count after rewrite", cnt, exp_count(50, 0, 65535));

        // R6: enable low gives silence, raising it restarts the phase
        @(negedge clk);
        en = 1'b0;
        run_window(300, cnt, first, dbl);
        check(cnt <= 1, "R6 at most a trailing tick as enable drops", cnt, 1);
        run_window(300, cnt, first, dbl);
        check(cnt == 0, "R6 no ticks with enable low", cnt, 0);
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        run_window(60, cnt, first, dbl);
        check(first == 3, "R6 phase restart on enable", first, 3);

        // R7: step zero silences the generator
        write_cfg(32'h0000_0000);
        run_window(400, cnt, first, dbl);
        check(cnt == 0, "R7 no ticks with step zero", cnt, 0);
        write_cfg(32'h0001_0000);
        run_window(400, cnt, first, dbl);
        check(cnt == 0, "R7 no ticks with scale set and step zero", cnt, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule